// File: doc/BRIEF.md
# Cache Auto-Prefetch Request Generator

This block sits beside the miss path of a data cache. It watches line-fill requests and decides whether one companion prefetch should follow each fill. If so, it computes the line address of that prefetch and chooses which way-lock mask the replacement logic must obey while the prefetched line is allocated. Cache lines are 32 bytes, so address bit 5 tells an even line from an odd one.

A 64-bit configuration word, written by software, sets the behaviour. It holds an enable bit, a two-bit policy field, a prefix-lock enable and two 16-bit masks in which a set bit marks a way that must not be allocated or replaced. There are three address policies. The first prefetches only the odd partner of an even line. The second always prefetches the line whose bit 5 is inverted. The third prefetches the following line, but stops at the last line of a 4 KiB page.

The prefetch output is registered and has a ready input. While the output is stalled, it holds its request, and any further qualifying fill is discarded and counted.

Top module: `line_prefetch_gen`

## Requirements
- R1: After reset, `cfg_rdata` is all zeros, `pf_valid` is 0 and `pf_drop_count` is 0.
- R2: A write with `cfg_we` high stores these fields: enable at bit 24, policy at bits [26:25], prefix-lock enable at bit 21, auto mask at bits [47:32] and prefix mask at bits [15:0]. They appear on `cfg_rdata` after that clock edge. Every other bit reads 0. A fill in the same cycle as a write uses the old settings.
- R3: While the enable bit is 0, no fill produces a prefetch.
- R4: Policy 00 (even-only): a fill whose address bit 5 is 0 prefetches the same address with bit 5 set (fill 0x00 gives 0x20). A fill with bit 5 equal to 1 gives no prefetch.
- R5: Policy 01 (pair toggle): every fill prefetches its own address with bit 5 inverted.
- R6: Policies 10 and 11 (next line): a fill prefetches line index + 1. If address bits [11:5] are all ones, no prefetch is made.
- R7: A qualifying fill, sampled at a clock edge while the output is not stalled, gives `pf_valid` high right after that edge. `pf_addr[4:0]` is always zero.
- R8: `pf_way_mask` carries bits [15:0] when `fill_prefixed` is 1 and the prefix-lock enable is 1. Otherwise it carries bits [47:32].
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid`, `pf_addr` and `pf_way_mask` hold. An edge with `pf_ready` high consumes the request.
- R10: A qualifying fill that arrives while the output is stalled is dropped, and `pf_drop_count` rises by one. A non-qualifying fill does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read-back |
| fill_valid | input | 1 | One-cycle fill request strobe |
| fill_addr | input | 32 | Physical address of the fill |
| fill_prefixed | input | 1 | Fill comes from a restricted-cache-prefixed instruction |
| pf_ready | input | 1 | Downstream accepts the prefetch |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | 32 | Prefetch line address, low 5 bits zero |
| pf_way_mask | output | 16 | Ways barred from allocation for this prefetch |
| pf_drop_count | output | 8 | Count of prefetches discarded while stalled, wraps |

## Verification
Two functions can fall in the same cycle: releasing a stalled prefetch, and accepting or dropping a new qualifying fill. The bench holds `pf_ready` low across several fills to force drops. It then raises ready in the same cycle as a fresh fill. The bench expects the held request to be consumed and the new one to load, with no drop counted. A configuration write in the same cycle as a fill is also provoked, and that fill must be judged against the old settings.

// File: rtl/lpf_pkg.sv
`timescale 1ns/1ps
package lpf_pkg;
  localparam int PF_WAYS = 16;
  localparam int CFG_W   = 64;

  // field positions in the configuration word
  localparam int POS_PFX_MASK  = 0;
  localparam int POS_PLK_EN    = 21;
  localparam int POS_ENABLE    = 24;
  localparam int POS_MODE      = 25;
  localparam int POS_AUTO_MASK = 32;

  typedef enum logic [1:0] {
    PF_EVEN_ONLY   = 2'b00,
    PF_PAIR_TOGGLE = 2'b01,
    PF_NEXT_LINE   = 2'b10,
    PF_NEXT_LINE_B = 2'b11
  } pf_mode_e;

  typedef struct packed {
    logic               enable;
    pf_mode_e           mode;
    logic               plk_en;
    logic [PF_WAYS-1:0] auto_mask;
    logic [PF_WAYS-1:0] pfx_mask;
  } pf_cfg_t;
endpackage

// File: rtl/lpf_cfg_reg.sv
`timescale 1ns/1ps
module lpf_cfg_reg
  import lpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output pf_cfg_t          cfg
);
  localparam logic [CFG_W-1:0] WR_MASK =
      ({{(CFG_W-PF_WAYS){1'b0}}, {PF_WAYS{1'b1}}} << POS_AUTO_MASK)
    | ({{(CFG_W-PF_WAYS){1'b0}}, {PF_WAYS{1'b1}}} << POS_PFX_MASK)
    | ({{(CFG_W-3){1'b0}}, 3'b111} << POS_ENABLE)
    | ({{(CFG_W-1){1'b0}}, 1'b1} << POS_PLK_EN);

  pf_cfg_t cfg_q;
  logic    unused_rsvd;

  assign unused_rsvd = ^(wdata & ~WR_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.enable    <= wdata[POS_ENABLE];
      cfg_q.mode      <= pf_mode_e'(wdata[POS_MODE +: 2]);
      cfg_q.plk_en    <= wdata[POS_PLK_EN];
      cfg_q.auto_mask <= wdata[POS_AUTO_MASK +: PF_WAYS];
      cfg_q.pfx_mask  <= wdata[POS_PFX_MASK +: PF_WAYS];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[POS_ENABLE]              = cfg_q.enable;
    rdata[POS_MODE +: 2]           = cfg_q.mode;
    rdata[POS_PLK_EN]              = cfg_q.plk_en;
    rdata[POS_AUTO_MASK +: PF_WAYS] = cfg_q.auto_mask;
    rdata[POS_PFX_MASK +: PF_WAYS]  = cfg_q.pfx_mask;
  end

  assign cfg = cfg_q;

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == ($past(wdata) & WR_MASK));

  // R2
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/lpf_addr_calc.sv
`timescale 1ns/1ps
module lpf_addr_calc
  import lpf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  pf_mode_e          mode,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] target,
  output logic              page_stop
);
  localparam int LINE_W = ADDR_W - LINE_BITS;
  localparam logic [ADDR_W-1:0] PAIR_BIT = {{(ADDR_W-1){1'b0}}, 1'b1} << LINE_BITS;

  function automatic logic is_odd_line(input logic [ADDR_W-1:0] a);
    return a[LINE_BITS];
  endfunction

  function automatic logic [ADDR_W-1:0] pair_line(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a ^ PAIR_BIT;
    r[LINE_BITS-1:0] = '0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] following_line(input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] idx;
    idx = a[ADDR_W-1:LINE_BITS] + 1'b1;
    return {idx, {LINE_BITS{1'b0}}};
  endfunction

  function automatic logic last_in_page(input logic [ADDR_W-1:0] a);
    return &a[PAGE_BITS-1:LINE_BITS];
  endfunction

  logic allow;

  always_comb begin
    page_stop = last_in_page(fill_addr);
    unique case (mode)
      PF_EVEN_ONLY: begin
        allow  = !is_odd_line(fill_addr);
        target = pair_line(fill_addr);
      end
      PF_PAIR_TOGGLE: begin
        allow  = 1'b1;
        target = pair_line(fill_addr);
      end
      default: begin
        allow  = !page_stop;
        target = following_line(fill_addr);
      end
    endcase
    hit = enable && fill_valid && allow;
  end

  // R6
  page_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && page_stop) |-> !hit);

  // R4
  odd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PF_EVEN_ONLY && fill_addr[LINE_BITS]) |-> !hit);

  // R5
  toggle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == PF_PAIR_TOGGLE) |-> target[LINE_BITS] != fill_addr[LINE_BITS]);
endmodule

// File: rtl/lpf_out_stage.sv
`timescale 1ns/1ps
module lpf_out_stage #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 16,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAYS-1:0]   req_mask,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [WAYS-1:0]   mask,
  output logic [DROP_W-1:0] drop_count,
  output logic              held,
  output logic              drop_evt
);
  assign held     = valid && !ready;
  assign drop_evt = held && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      addr       <= '0;
      mask       <= '0;
      drop_count <= '0;
    end else begin
      if (!held) begin
        valid <= req_valid;
        if (req_valid) begin
          addr <= req_addr;
          mask <= req_mask;
        end
      end
      if (drop_evt) drop_count <= drop_count + 1'b1;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> valid && $stable(addr) && $stable(mask));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !req_valid) |=> !valid);

  // R10
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> drop_count == DROP_W'($past(drop_count) + 1'b1));

  // R10
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_count));
endmodule

// File: rtl/line_prefetch_gen.sv
`timescale 1ns/1ps
module line_prefetch_gen
  import lpf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12,
  parameter int DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_prefixed,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [15:0]       pf_way_mask,
  output logic [DROP_W-1:0] pf_drop_count
);
  pf_cfg_t             cfg;
  logic                hit;
  logic [ADDR_W-1:0]   target;
  logic                page_stop;
  logic [PF_WAYS-1:0]  sel_mask;
  logic                held;
  logic                drop_evt;

  lpf_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  lpf_addr_calc #(
    .ADDR_W    (ADDR_W),
    .LINE_BITS (LINE_BITS),
    .PAGE_BITS (PAGE_BITS)
  ) u_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg.enable),
    .mode       (cfg.mode),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .hit        (hit),
    .target     (target),
    .page_stop  (page_stop)
  );

  always_comb begin
    sel_mask = (fill_prefixed && cfg.plk_en) ? cfg.pfx_mask : cfg.auto_mask;
  end

  lpf_out_stage #(
    .ADDR_W (ADDR_W),
    .WAYS   (PF_WAYS),
    .DROP_W (DROP_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (hit),
    .req_addr   (target),
    .req_mask   (sel_mask),
    .ready      (pf_ready),
    .valid      (pf_valid),
    .addr       (pf_addr),
    .mask       (pf_way_mask),
    .drop_count (pf_drop_count),
    .held       (held),
    .drop_evt   (drop_evt)
  );

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.enable && !held) |=> !pf_valid);

  // R7
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[LINE_BITS-1:0] == '0);

  // R7
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !held) |=> pf_valid && pf_addr == $past(target));

  // R8
  pfx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !held && fill_prefixed && cfg.plk_en) |=> pf_way_mask == $past(cfg.pfx_mask));

  // R8
  auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !held && !(fill_prefixed && cfg.plk_en)) |=> pf_way_mask == $past(cfg.auto_mask));

  // R6
  page_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode[1] && page_stop && !held) |=> !pf_valid);
endmodule

// File: tb/line_prefetch_gen_test.sv
`timescale 1ns/1ps
module line_prefetch_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic        fill_prefixed;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic [15:0] pf_way_mask;
  logic [7:0]  pf_drop_count;

  always #2.5 clk = ~clk;

  line_prefetch_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .fill_valid    (fill_valid),
    .fill_addr     (fill_addr),
    .fill_prefixed (fill_prefixed),
    .pf_ready      (pf_ready),
    .pf_valid      (pf_valid),
    .pf_addr       (pf_addr),
    .pf_way_mask   (pf_way_mask),
    .pf_drop_count (pf_drop_count)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  bit              m_valid;
  longint unsigned m_addr;
  logic [15:0]     m_mask;
  int              m_drop;
  logic [63:0]     m_cfg;

  function automatic logic [63:0] keep_bits(input logic [63:0] d);
    logic [63:0] r;
    r = 64'd0;
    r[47:32] = d[47:32];
    r[26]    = d[26];
    r[25]    = d[25];
    r[24]    = d[24];
    r[21]    = d[21];
    r[15:0]  = d[15:0];
    return r;
  endfunction

  function automatic logic [63:0] mkcfg(input bit en, input int mode, input bit plk,
                                        input logic [15:0] amask, input logic [15:0] pmask);
    logic [63:0] r;
    r = 64'd0;
    r[24] = en;
    r[26:25] = 2'(mode);
    r[21] = plk;
    r[47:32] = amask;
    r[15:0] = pmask;
    return r;
  endfunction

  function automatic bit ref_target(input longint unsigned a, input int mode,
                                    output longint unsigned t);
    longint unsigned ln;
    ln = a / 32;
    t = 0;
    if (mode == 0) begin
      if (ln % 2 == 0) begin t = (ln + 1) * 32; return 1'b1; end
      return 1'b0;
    end else if (mode == 1) begin
      t = (ln % 2 == 1) ? (ln - 1) * 32 : (ln + 1) * 32;
      return 1'b1;
    end else begin
      if (ln % 128 == 127) return 1'b0;
      t = ((ln + 1) * 32) % 64'h1_0000_0000;
      return 1'b1;
    end
  endfunction

  task automatic compare(input string tag);
    bit ok;
    ok = (pf_valid === m_valid) && (pf_drop_count === 8'(m_drop)) && (cfg_rdata === m_cfg);
    if (m_valid) ok = ok && (pf_addr === 32'(m_addr)) && (pf_way_mask === m_mask);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got v=%0b a=%h m=%h d=%0d cfg=%h exp v=%0b a=%h m=%h d=%0d cfg=%h",
               tag, pf_valid, pf_addr, pf_way_mask, pf_drop_count, cfg_rdata,
               m_valid, 32'(m_addr), m_mask, m_drop, m_cfg);
    end
  endtask

  // one clock: advance the reference from the driven inputs, then compare
  task automatic cycle(input string tag);
    bit held, want;
    longint unsigned t;
    logic [15:0] sel;
    held = m_valid && !pf_ready;
    want = fill_valid && m_cfg[24] && ref_target(64'(fill_addr), int'(m_cfg[26:25]), t);
    sel = (fill_prefixed && m_cfg[21]) ? m_cfg[15:0] : m_cfg[47:32];
    if (held) begin
      if (want) m_drop = (m_drop + 1) % 256;
    end else begin
      m_valid = want;
      if (want) begin m_addr = t; m_mask = sel; end
    end
    if (cfg_we) m_cfg = keep_bits(cfg_wdata);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic wr_cfg(input logic [63:0] d, input string tag);
    cfg_we = 1'b1; cfg_wdata = d;
    cycle(tag);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic do_fill(input logic [31:0] a, input bit pfx, input string tag);
    fill_valid = 1'b1; fill_addr = a; fill_prefixed = pfx;
    cycle(tag);
    fill_valid = 1'b0; fill_addr = '0; fill_prefixed = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    string tag;
    logic [31:0] addrs [6];
    addrs[0] = 32'h0000_1000; addrs[1] = 32'h0000_1020; addrs[2] = 32'h0000_1FE0;
    addrs[3] = 32'h0000_1FC0; addrs[4] = 32'hFFFF_FFE0; addrs[5] = 32'h1234_5677;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; fill_valid = 1'b0;
    fill_addr = '0; fill_prefixed = 1'b0; pf_ready = 1'b1;
    m_valid = 0; m_addr = 0; m_mask = '0; m_drop = 0; m_cfg = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state");
    rst_n = 1'b1;
    cycle("R1 idle after reset");

    // sweep policies, enable and prefix flag
    for (int en = 0; en < 2; en++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int plk = 0; plk < 2; plk++) begin
          wr_cfg(mkcfg(en[0], mode, plk[0], 16'hA5C3, 16'h0F1E), "R2 cfg write");
          for (int i = 0; i < 6; i++) begin
            for (int p = 0; p < 2; p++) begin
              if (en == 0) tag = "R3 disabled fill";
              else if (p == 1) tag = "R8 mask select";
              else if (mode == 0) tag = "R4 even-only";
              else if (mode == 1) tag = "R5 pair toggle";
              else tag = "R6 next line";
              do_fill(addrs[i], p[0], tag);
              cycle("R7 issue then idle");
            end
          end
        end
      end
    end

    // stall with drops, then release in the same cycle as a new fill
    wr_cfg(mkcfg(1'b1, 1, 1'b0, 16'h00FF, 16'hFF00), "R2 cfg write");
    pf_ready = 1'b0;
    do_fill(32'h0000_2000, 1'b0, "R9 load before stall");
    do_fill(32'h0000_3000, 1'b0, "R10 drop while stalled");
    cycle("R9 hold while stalled");
    do_fill(32'h0000_3040, 1'b0, "R10 second drop");
    pf_ready = 1'b1;
    do_fill(32'h0000_4020, 1'b0, "R9 release with new fill");
    cycle("R9 consumed");

    // non-qualifying fill while stalled does not count
    wr_cfg(mkcfg(1'b1, 0, 1'b0, 16'h1111, 16'h2222), "R2 cfg write");
    pf_ready = 1'b0;
    do_fill(32'h0000_5000, 1'b0, "R9 load before stall");
    do_fill(32'h0000_5020, 1'b0, "R10 odd fill no drop");
    pf_ready = 1'b1;
    cycle("R9 consumed");

    // write and fill in the same cycle: old settings apply
    wr_cfg(64'd0, "R2 cfg clear");
    cfg_we = 1'b1; cfg_wdata = mkcfg(1'b1, 1, 1'b0, 16'h3C3C, 16'h0);
    fill_valid = 1'b1; fill_addr = 32'h0000_6000;
    cycle("R2 same-cycle write and fill");
    cfg_we = 1'b0; fill_valid = 1'b0;
    cycle("R2 no prefetch from old settings");
    do_fill(32'h0000_6000, 1'b0, "R2 new settings active");
    cycle("R7 idle");

    // reserved bits
    wr_cfg(64'hFFFF_FFFF_FFFF_FFFF, "R2 reserved bits read zero");
    cycle("R2 hold");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule